// File: doc/BRIEF.md
# Streaming-Start Compute Shell

This block wraps a fixed-latency arithmetic core behind an invocation handshake. A caller launches one invocation by holding `start` high with the argument on `arg_in`. The argument is captured in the cycle where `start` and `ready_out` are both high. After `LAT` cycles the core presents `result` with `done` high. The invocation retires in the cycle where `done` and `ready_in` are both high, so a downstream consumer can hold results back. Each result is `arg_in * (arg_in + 1) + offset`. The `offset` term is a sideband register written through `reg_wr`/`reg_wdata`.

The parameter `II` selects how launches are spaced:

- With `II = 0` the shell runs one invocation at a time.
- With `II = N > 0` it is pipelined, and accepted launches are at least N cycles apart.

The parameter `STALL_FREE` makes the shell ignore `ready_in`, as if it were tied high. The core is then never held.

A launch controller has three states:

- `LS_OPEN`: ready for a launch.
- `LS_SPACE`: counting out the initiation gap.
- `LS_WAIT`: non-pipelined, with an invocation in flight.

Its transitions are:

- OPEN→SPACE on an accept when `II > 1`.
- OPEN→WAIT on an accept when `II = 0`.
- OPEN→OPEN on an accept when `II = 1`.
- SPACE→OPEN when the gap counter reaches zero.
- WAIT→OPEN on the retiring handshake.

Results travel through a shift pipeline with one valid bit per stage. The whole pipeline freezes while the output stage holds a result that is not taken.

Top module: `strm_kernel_shell`

## Requirements
- R1: While reset is low and in the first cycle after it, `done` is 0 and `ready_out` is 1.
- R2: Every accepted launch produces `result = arg*(arg+1) + offset`, truncated to `2*DATA_W` bits. With no stall, `done` is high exactly `LAT` cycles after the accepting cycle.
- R3: The offset used by a launch is the register value written in an earlier cycle. A write in the same cycle as the accepting start is not seen by that launch, but it is seen by the next one.
- R4: While `done` is high and `ready_in` is low (with `STALL_FREE = 0`), `ready_out` is 0, `done` stays high and `result` does not change.
- R5: With `II = 0`, after an accepted launch `ready_out` stays 0 until that invocation has retired.
- R6: With `II = N > 0`, two accepted launches are at least N cycles apart. With `II = 1` and no stall, `ready_out` stays high, so back-to-back starts give back-to-back `done` cycles.
- R7: With `STALL_FREE = 1`, `ready_in` has no effect: every result retires in the cycle `done` is high.
- R8: A start while `ready_out` is 0 launches nothing and produces no result.
- R9: Results retire in launch order, and none is lost or duplicated under backpressure.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Launch request |
| arg_in | input | DATA_W | Argument captured with the launch |
| ready_out | output | 1 | Shell can accept a launch this cycle |
| reg_wr | input | 1 | Write strobe of the offset register |
| reg_wdata | input | DATA_W | Offset register write value |
| ready_in | input | 1 | Downstream can take a result (ignored when STALL_FREE=1) |
| done | output | 1 | Result valid |
| result | output | 2*DATA_W | Computed value of the oldest unretired invocation |

## Verification
A wrong launch state appears at `ready_out` in the cycle after an accept:

- A controller that leaves `LS_WAIT` early or skips `LS_SPACE` accepts a launch too soon.
- A controller that sticks shows a start that is never taken.

A broken stage valid bit, or a wrong freeze condition, shows up at `done` within `LAT` cycles of the launch. It appears as a missing, duplicated, misordered or shifted result, or as a value that changes while held. A stale or early offset shows up in the first result after the write.

// File: rtl/strm_kernel_shell_pkg.sv
package strm_kernel_shell_pkg;

    typedef enum logic [1:0] {
        LS_OPEN  = 2'd0,
        LS_SPACE = 2'd1,
        LS_WAIT  = 2'd2
    } launch_state_t;

endpackage

// File: rtl/strm_sideband_reg.sv
module strm_sideband_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] value_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            value_q <= '0;
        else if (wr_en)
            value_q <= wr_data;
    end
endmodule

// File: rtl/strm_launch_ctl.sv
module strm_launch_ctl
    import strm_kernel_shell_pkg::*;
#(
    parameter int II = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic finish,
    input  logic hold,
    output logic ready_out
);
    localparam int CW    = (II > 2) ? $clog2(II) : 1;
    localparam int LOADV = (II > 2) ? II - 2 : 0;

    launch_state_t state_q, state_d;
    logic [CW-1:0] gap_q;
    logic          accept;

    assign accept = start && ready_out;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= LS_OPEN;
        else
            state_q <= state_d;
    end

    // initiation gap counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            gap_q <= '0;
        else if (accept)
            gap_q <= CW'(LOADV);
        else if (state_q == LS_SPACE && gap_q != '0)
            gap_q <= gap_q - 1'b1;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LS_OPEN: begin
                if (accept) begin
                    if (II == 0)
                        state_d = LS_WAIT;
                    else if (II > 1)
                        state_d = LS_SPACE;
                end
            end
            LS_SPACE: if (gap_q == '0) state_d = LS_OPEN;
            LS_WAIT:  if (finish)      state_d = LS_OPEN;
            default:  state_d = LS_OPEN;
        endcase
    end

    // outputs
    always_comb begin
        ready_out = (state_q == LS_OPEN) && !hold;
    end
endmodule

// File: rtl/strm_calc_pipe.sv
module strm_calc_pipe #(
    parameter int DW  = 8,
    parameter int LAT = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          advance,
    input  logic          load,
    input  logic [DW-1:0] arg,
    input  logic [DW-1:0] offset,
    output logic          out_valid,
    output logic [2*DW-1:0] out_data
);
    localparam int RW = 2 * DW;

    typedef struct packed {
        logic          valid;
        logic [RW-1:0] data;
    } stage_t;

    stage_t        stg [LAT];
    logic [RW-1:0] wide;
    logic [RW-1:0] calc;

    assign wide = RW'(arg);
    assign calc = wide * (wide + 1'b1) + RW'(offset);

    for (genvar g = 0; g < LAT; g++) begin : g_stage
        if (g == 0) begin : g_head
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    stg[0] <= '0;
                else if (advance) begin
                    stg[0].valid <= load;
                    stg[0].data  <= calc;
                end
            end
        end else begin : g_body
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    stg[g] <= '0;
                else if (advance)
                    stg[g] <= stg[g-1];
            end
        end
    end

    assign out_valid = stg[LAT-1].valid;
    assign out_data  = stg[LAT-1].data;
endmodule

// File: rtl/strm_kernel_shell.sv
module strm_kernel_shell #(
    parameter int DATA_W     = 8,
    parameter int LAT        = 3,
    parameter int II         = 1,
    parameter bit STALL_FREE = 1'b0,
    localparam int RES_W     = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [DATA_W-1:0] arg_in,
    output logic              ready_out,
    input  logic              reg_wr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic              ready_in,
    output logic              done,
    output logic [RES_W-1:0]  result
);
    logic              rdy_eff;
    logic              hold;
    logic [DATA_W-1:0] offset_q;

    if (STALL_FREE) begin : g_nostall
        assign rdy_eff = 1'b1;
    end else begin : g_stall
        assign rdy_eff = ready_in;
    end

    assign hold = done && !rdy_eff;

    strm_sideband_reg #(.W(DATA_W)) u_offset (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (reg_wr),
        .wr_data (reg_wdata),
        .value_q (offset_q)
    );

    strm_launch_ctl #(.II(II)) u_launch (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .finish    (done && rdy_eff),
        .hold      (hold),
        .ready_out (ready_out)
    );

    strm_calc_pipe #(.DW(DATA_W), .LAT(LAT)) u_pipe (
        .clk       (clk),
        .rst_n     (rst_n),
        .advance   (!hold),
        .load      (start && ready_out),
        .arg       (arg_in),
        .offset    (offset_q),
        .out_valid (done),
        .out_data  (result)
    );
endmodule

// File: rtl/strm_kernel_shell_chk.sv
module strm_kernel_shell_chk #(
    parameter int II         = 1,
    parameter int LAT        = 3,
    parameter bit STALL_FREE = 1'b0,
    parameter int RES_W      = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             ready_out,
    input logic             ready_in,
    input logic             done,
    input logic [RES_W-1:0] result
);
    localparam int FW = $clog2(LAT + 2);

    logic [FW-1:0] inflight;
    logic          acc, ret;

    assign acc = start && ready_out;
    assign ret = done && (STALL_FREE || ready_in);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            inflight <= '0;
        else
            inflight <= inflight + FW'(acc) - FW'(ret);
    end

    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!STALL_FREE && done && !ready_in) |=> (done && $stable(result)));

    p_block_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!STALL_FREE && done && !ready_in) |-> !ready_out);

    p_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (II == 0 && acc) |=> !ready_out);

    p_space_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (II > 1 && acc) |=> !ready_out);

    p_open_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (STALL_FREE && II == 1) |-> ready_out);

    p_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (inflight != '0 && inflight <= FW'(LAT)));
endmodule

bind strm_kernel_shell strm_kernel_shell_chk #(
    .II(II), .LAT(LAT), .STALL_FREE(STALL_FREE), .RES_W(RES_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .ready_out(ready_out),
    .ready_in(ready_in), .done(done), .result(result)
);

// File: tb/test_strm_kernel_shell.sv
module tb_score #(
    parameter int II  = 1,
    parameter int LAT = 3,
    parameter bit SF  = 1'b0,
    parameter int DW  = 4
) (
    input logic          clk,
    input logic          active,
    input logic          exact,
    input logic          start,
    input logic [DW-1:0] din,
    input logic          wr,
    input logic [DW-1:0] wdata,
    input logic          ready_in,
    input logic          ready_out,
    input logic          done,
    input logic [2*DW-1:0] result
);
    int n_chk = 0, n_fail = 0, n_acc = 0, n_ret = 0;
    int cyc = 0, last_acc = -1000, off = 0;
    int q_val[$];
    int q_cyc[$];

    task automatic chk(bit ok, string tag, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s (II=%0d SF=%0d) cycle %0d: actual %0d expected %0d",
                     tag, II, SF, cyc, act, exp);
        end
    endtask

    always @(negedge clk) begin
        cyc++;
        if (active) begin
            if (done) begin
                if (q_val.size() == 0)
                    chk(0, "R8 R9 unexpected done", int'(result), -1);
                else begin
                    chk(int'(result) == q_val[0], "R2 R4 R9 result", int'(result), q_val[0]);
                    if (SF || ready_in) begin
                        if (exact)
                            chk(cyc == q_cyc[0] + LAT, "R2 latency", cyc - q_cyc[0], LAT);
                        void'(q_val.pop_front());
                        void'(q_cyc.pop_front());
                        n_ret++;
                    end
                end
            end
            if (!SF && done && !ready_in)
                chk(!ready_out, "R4 ready_out", int'(ready_out), 0);
            if (II == 1 && !(!SF && done && !ready_in))
                chk(ready_out, "R6 stays ready", int'(ready_out), 1);
            if (start && ready_out) begin
                if (II == 0)
                    chk(q_val.size() == 0, "R5 one in flight", q_val.size(), 0);
                else
                    chk(cyc - last_acc >= II, "R6 spacing", cyc - last_acc, II);
                q_val.push_back((int'(din) * (int'(din) + 1) + off) % (1 << (2 * DW)));
                q_cyc.push_back(cyc);
                last_acc = cyc;
                n_acc++;
            end
            if (wr) off = int'(wdata);   // R3: visible from the next cycle
        end
    end
endmodule

module test_strm_kernel_shell;
    localparam int DW = 4;
    localparam int LT = 3;
    localparam int RW = 2 * DW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0, wr = 1'b0, ready_in = 1'b1;
    logic active = 1'b0, exact = 1'b1;
    logic [DW-1:0] din = '0, wdata = '0;
    logic ro_a, ro_b, ro_c, dn_a, dn_b, dn_c;
    logic [RW-1:0] rs_a, rs_b, rs_c;
    int n_chk = 0, n_fail = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    strm_kernel_shell #(.DATA_W(DW), .LAT(LT), .II(1), .STALL_FREE(1'b0)) i_strm_kernel_shell (
        .clk(clk), .rst_n(rst_n), .start(start), .arg_in(din), .ready_out(ro_a),
        .reg_wr(wr), .reg_wdata(wdata), .ready_in(ready_in), .done(dn_a), .result(rs_a));
    strm_kernel_shell #(.DATA_W(DW), .LAT(LT), .II(0), .STALL_FREE(1'b0)) i_strm_kernel_shell_np (
        .clk(clk), .rst_n(rst_n), .start(start), .arg_in(din), .ready_out(ro_b),
        .reg_wr(wr), .reg_wdata(wdata), .ready_in(ready_in), .done(dn_b), .result(rs_b));
    strm_kernel_shell #(.DATA_W(DW), .LAT(LT), .II(3), .STALL_FREE(1'b1)) i_strm_kernel_shell_sf (
        .clk(clk), .rst_n(rst_n), .start(start), .arg_in(din), .ready_out(ro_c),
        .reg_wr(wr), .reg_wdata(wdata), .ready_in(ready_in), .done(dn_c), .result(rs_c));

    tb_score #(.II(1), .LAT(LT), .SF(1'b0), .DW(DW)) i_sb_a (.clk(clk), .active(active), .exact(exact),
        .start(start), .din(din), .wr(wr), .wdata(wdata), .ready_in(ready_in),
        .ready_out(ro_a), .done(dn_a), .result(rs_a));
    tb_score #(.II(0), .LAT(LT), .SF(1'b0), .DW(DW)) i_sb_b (.clk(clk), .active(active), .exact(exact),
        .start(start), .din(din), .wr(wr), .wdata(wdata), .ready_in(ready_in),
        .ready_out(ro_b), .done(dn_b), .result(rs_b));
    tb_score #(.II(3), .LAT(LT), .SF(1'b1), .DW(DW)) i_sb_c (.clk(clk), .active(active), .exact(exact),
        .start(start), .din(din), .wr(wr), .wdata(wdata), .ready_in(ready_in),
        .ready_out(ro_c), .done(dn_c), .result(rs_c));

    task automatic chk(bit ok, string tag, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic drv(bit s, int d, bit w, int wd);
        @(posedge clk);
        #1;
        start = s; din = DW'(d); wr = w; wdata = DW'(wd);
    endtask

    task automatic idle(int n);
        for (int k = 0; k < n; k++) drv(1'b0, 0, 1'b0, 0);
    endtask

    task automatic report;
        int tc, tf;
        tc = n_chk + i_sb_a.n_chk + i_sb_b.n_chk + i_sb_c.n_chk;
        tf = n_fail + i_sb_a.n_fail + i_sb_b.n_fail + i_sb_c.n_fail;
        $display("  [TB] %0d tests run, %0d failed", tc, tf);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_chk++; n_fail++;
            $display("FAIL watchdog expired: actual timeout expected completion");
            report();
            $finish;
        end
    end

    initial begin
        int c_before;
        // R1: reset state
        repeat (3) @(negedge clk);
        chk(!dn_a && !dn_b && !dn_c, "R1 done low in reset", int'(dn_a | dn_b | dn_c), 0);
        @(posedge clk); #1 rst_n = 1'b1; active = 1'b1;
        @(negedge clk);
        chk(ro_a && ro_b && ro_c, "R1 ready after reset", int'({ro_a, ro_b, ro_c}), 7);
        chk(!dn_a && !dn_b && !dn_c, "R1 done after reset", int'({dn_a, dn_b, dn_c}), 0);

        // R2 R5 R6 R8: argument sweep, no backpressure
        for (int i = 0; i < 48; i++) drv(i % 5 != 4, i % 16, i == 20, 7);
        idle(12);

        // R3: write in the accepting cycle is seen only by the next launch
        drv(1'b1, 2, 1'b1, 9);
        drv(1'b1, 2, 1'b0, 0);
        drv(1'b0, 0, 1'b0, 0);
        @(posedge clk);
        @(negedge clk);
        chk(dn_a && rs_a == RW'(13), "R3 old offset", int'(rs_a), 13);
        @(negedge clk);
        chk(dn_a && rs_a == RW'(15), "R3 new offset", int'(rs_a), 15);
        idle(12);

        // R4 R7: backpressure
        exact = 1'b0;
        c_before = i_sb_c.n_ret;
        @(posedge clk); #1 ready_in = 1'b0;
        for (int i = 0; i < 12; i++) drv(1'b1, (3 * i) % 16, 1'b0, 0);
        @(negedge clk);
        chk(!ro_a, "R4 ready_out low when held", int'(ro_a), 0);
        chk(dn_a, "R4 done held", int'(dn_a), 1);
        chk(i_sb_c.n_ret > c_before, "R7 retires without ready_in", i_sb_c.n_ret - c_before, 1);
        idle(3);
        @(posedge clk); #1 ready_in = 1'b1;
        idle(15);

        // R4 R5 R6 R9: mixed start and ready_in patterns
        for (int i = 0; i < 60; i++) begin
            @(posedge clk); #1;
            ready_in = (i % 3 != 0);
            start = (i % 2 == 0) || (i % 7 == 1);
            din = DW'((5 * i + 1) % 16);
            wr = (i % 13 == 6);
            wdata = DW'(i % 16);
        end
        @(posedge clk); #1 ready_in = 1'b1; start = 1'b0; wr = 1'b0;
        idle(20);

        // R8 R9: every accepted launch retired, nothing extra
        @(negedge clk);
        chk(i_sb_a.q_val.size() == 0 && i_sb_a.n_acc == i_sb_a.n_ret, "R8 R9 drained II=1",
            i_sb_a.n_ret, i_sb_a.n_acc);
        chk(i_sb_b.q_val.size() == 0 && i_sb_b.n_acc == i_sb_b.n_ret, "R8 R9 drained II=0",
            i_sb_b.n_ret, i_sb_b.n_acc);
        chk(i_sb_c.q_val.size() == 0 && i_sb_c.n_acc == i_sb_c.n_ret, "R7 R9 drained stall-free",
            i_sb_c.n_ret, i_sb_c.n_acc);
        chk(!dn_a && !dn_b && !dn_c, "R9 idle after drain", int'({dn_a, dn_b, dn_c}), 0);

        if (!finished) begin
            finished = 1'b1;
            report();
            $finish;
        end
    end
endmodule